// File: doc/BRIEF.md
# Segmented Effective Address Generator

This block turns the operand fields of a memory reference into an address. From one request it picks the register parts that the addressing mode names, adds them into a 16-bit offset, and picks the segment. The segment defaults to the stack segment when the base pointer takes part and to the data segment otherwise, unless a segment override is supplied. It then forms the 20-bit physical address: the segment value shifted left by four bits plus the offset.

Requests arrive on a valid/ready stream and results leave on a second valid/ready stream, with one output register between them. A request is taken on any edge where `in_valid` and `in_ready` are both high. `in_ready` is high when the output register is empty or is being drained on that same edge. A result stays on the outputs, unchanged, until the consumer takes it with `out_ready`. A new request can be taken on the edge that drains the old result, so with `out_ready` held high the block accepts one request per cycle.

Top module: `eag_top`

## Requirements
- R1: `out_phys` equals (segment value × 16 + `out_offset`) modulo 2^20, where the segment value is the register that `out_seg` names. The segment codes are 0 = extra, 1 = code, 2 = stack, 3 = data.
- R2: Mode code 0 (direct) uses `disp` alone as the offset and selects the data segment (code 3).
- R3: Mode code 1 (indirect) uses the pointer that `ptr_sel` names (0 = BX, 1 = BP, 2 = SI, 3 = DI) as the offset. It selects the stack segment when that pointer is BP and the data segment for the other three.
- R4: Mode code 2 (base+index) adds the base (`base_sel` 0 = BX, 1 = BP) to the index (`index_sel` 0 = SI, 1 = DI). It selects the stack segment when the base is BP and the data segment otherwise.
- R5: Mode code 3 (relative) adds `disp`, taken as a two's-complement value, to the `ptr_sel` pointer. The segment follows the rule of R3, and the offset wraps modulo 2^16.
- R6: Mode code 4 (base+index+displacement) adds the base, the index and `disp` modulo 2^16. The segment follows the rule of R4.
- R7: When `ovr_valid` is high with a legal mode, `ovr_seg` replaces the default segment.
- R8: Mode codes 5, 6 and 7 produce `out_err` = 1 with offset, segment code and physical address all zero, whatever the override inputs hold. Legal modes give `out_err` = 0.
- R9: `in_ready` = !`out_valid` || `out_ready`. An accepted request appears with `out_valid` on the next cycle. A result that has not been taken holds all of its output fields stable.
- R10: While `rst_n` is low, `out_valid` is low and no request is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| mode | input | 3 | Addressing mode code |
| ptr_sel | input | 2 | Single pointer for modes 1 and 3 |
| base_sel | input | 1 | Base register for modes 2 and 4 |
| index_sel | input | 1 | Index register for modes 2 and 4 |
| disp | input | 16 | Displacement, two's complement |
| reg_bx | input | 16 | BX value |
| reg_bp | input | 16 | BP value |
| reg_si | input | 16 | SI value |
| reg_di | input | 16 | DI value |
| seg_es | input | 16 | Extra segment value |
| seg_cs | input | 16 | Code segment value |
| seg_ss | input | 16 | Stack segment value |
| seg_ds | input | 16 | Data segment value |
| ovr_valid | input | 1 | Segment override present |
| ovr_seg | input | 2 | Override segment code |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_offset | output | 16 | Computed offset |
| out_seg | output | 2 | Chosen segment code |
| out_phys | output | 20 | Physical address |
| out_err | output | 1 | Illegal mode flag |

## Verification
The only internal state is the output register and its valid bit, so any fault shows at the ports one cycle after the request that caused it. A wrong operand select or a wrong default segment gives a wrong offset, segment code or address on that same result. A corrupted valid bit shows as a lost or duplicated result, or as a wrong `in_ready`. The reference model checks every output field on every cycle, including the cycles of a stall, so a result that changes while it waits is caught on the first cycle it changes.

// File: rtl/eag_pkg.sv
package eag_pkg;
  typedef enum logic [2:0] {
    AM_DIRECT       = 3'd0,
    AM_INDIRECT     = 3'd1,
    AM_BASE_IDX     = 3'd2,
    AM_REL          = 3'd3,
    AM_BASE_IDX_REL = 3'd4
  } amode_e;

  typedef enum logic [1:0] {
    SEG_ES = 2'd0,
    SEG_CS = 2'd1,
    SEG_SS = 2'd2,
    SEG_DS = 2'd3
  } seg_e;

  localparam logic [1:0] PTR_BX = 2'd0;
  localparam logic [1:0] PTR_BP = 2'd1;
  localparam logic [1:0] PTR_SI = 2'd2;
  localparam logic [1:0] PTR_DI = 2'd3;
endpackage

// File: rtl/eag_operand_sel.sv
module eag_operand_sel
  import eag_pkg::*;
#(
  parameter int OW = 16
) (
  input  logic [2:0]    mode,
  input  logic [1:0]    ptr_sel,
  input  logic          base_sel,
  input  logic          index_sel,
  input  logic [OW-1:0] disp,
  input  logic [OW-1:0] reg_bx,
  input  logic [OW-1:0] reg_bp,
  input  logic [OW-1:0] reg_si,
  input  logic [OW-1:0] reg_di,
  output logic [OW-1:0] offset,
  output logic          uses_bp,
  output logic          legal
);
  logic [OW-1:0] ptr_val;
  logic [OW-1:0] base_val;
  logic [OW-1:0] idx_val;

  always_comb begin
    case (ptr_sel)
      PTR_BX:  ptr_val = reg_bx;
      PTR_BP:  ptr_val = reg_bp;
      PTR_SI:  ptr_val = reg_si;
      default: ptr_val = reg_di;
    endcase
    base_val = base_sel ? reg_bp : reg_bx;
    idx_val  = index_sel ? reg_di : reg_si;
  end

  // Sums are OW bits wide, so the offset wraps naturally.
  always_comb begin
    offset  = '0;
    uses_bp = 1'b0;
    legal   = 1'b1;
    case (mode)
      AM_DIRECT: begin
        offset = disp;
      end
      AM_INDIRECT: begin
        offset  = ptr_val;
        uses_bp = (ptr_sel == PTR_BP);
      end
      AM_BASE_IDX: begin
        offset  = base_val + idx_val;
        uses_bp = base_sel;
      end
      AM_REL: begin
        offset  = ptr_val + disp;
        uses_bp = (ptr_sel == PTR_BP);
      end
      AM_BASE_IDX_REL: begin
        offset  = base_val + idx_val + disp;
        uses_bp = base_sel;
      end
      default: begin
        legal = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/eag_seg_pick.sv
module eag_seg_pick
  import eag_pkg::*;
#(
  parameter int OW = 16
) (
  input  logic          legal,
  input  logic          uses_bp,
  input  logic          ovr_valid,
  input  logic [1:0]    ovr_seg,
  input  logic [OW-1:0] seg_es,
  input  logic [OW-1:0] seg_cs,
  input  logic [OW-1:0] seg_ss,
  input  logic [OW-1:0] seg_ds,
  output logic [1:0]    seg_id,
  output logic [OW-1:0] seg_val
);
  always_comb begin
    if (!legal)         seg_id = SEG_ES;
    else if (ovr_valid) seg_id = ovr_seg;
    else if (uses_bp)   seg_id = SEG_SS;
    else                seg_id = SEG_DS;
  end

  always_comb begin
    case (seg_id)
      SEG_ES:  seg_val = seg_es;
      SEG_CS:  seg_val = seg_cs;
      SEG_SS:  seg_val = seg_ss;
      default: seg_val = seg_ds;
    endcase
  end
endmodule

// File: rtl/eag_phys.sv
module eag_phys #(
  parameter int OW        = 16,
  parameter int SEG_SHIFT = 4
) (
  input  logic                    legal,
  input  logic [OW-1:0]           seg_val,
  input  logic [OW-1:0]           offset,
  output logic [OW+SEG_SHIFT-1:0] phys
);
  localparam int PW = OW + SEG_SHIFT;

  logic [PW-1:0] seg_ext;
  logic [PW-1:0] off_ext;

  assign seg_ext = {seg_val, {SEG_SHIFT{1'b0}}};
  assign off_ext = {{SEG_SHIFT{1'b0}}, offset};
  assign phys    = legal ? (seg_ext + off_ext) : '0;
endmodule

// File: rtl/eag_top.sv
module eag_top #(
  parameter int OW        = 16,
  parameter int SEG_SHIFT = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [2:0]              mode,
  input  logic [1:0]              ptr_sel,
  input  logic                    base_sel,
  input  logic                    index_sel,
  input  logic [OW-1:0]           disp,
  input  logic [OW-1:0]           reg_bx,
  input  logic [OW-1:0]           reg_bp,
  input  logic [OW-1:0]           reg_si,
  input  logic [OW-1:0]           reg_di,
  input  logic [OW-1:0]           seg_es,
  input  logic [OW-1:0]           seg_cs,
  input  logic [OW-1:0]           seg_ss,
  input  logic [OW-1:0]           seg_ds,
  input  logic                    ovr_valid,
  input  logic [1:0]              ovr_seg,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [OW-1:0]           out_offset,
  output logic [1:0]              out_seg,
  output logic [OW+SEG_SHIFT-1:0] out_phys,
  output logic                    out_err
);
  localparam int PW = OW + SEG_SHIFT;

  logic [OW-1:0] c_offset;
  logic          c_uses_bp;
  logic          c_legal;
  logic [1:0]    c_seg_id;
  logic [OW-1:0] c_seg_val;
  logic [PW-1:0] c_phys;
  logic          accept;

  eag_operand_sel #(.OW(OW)) u_opsel (
    .mode      (mode),
    .ptr_sel   (ptr_sel),
    .base_sel  (base_sel),
    .index_sel (index_sel),
    .disp      (disp),
    .reg_bx    (reg_bx),
    .reg_bp    (reg_bp),
    .reg_si    (reg_si),
    .reg_di    (reg_di),
    .offset    (c_offset),
    .uses_bp   (c_uses_bp),
    .legal     (c_legal)
  );

  eag_seg_pick #(.OW(OW)) u_seg (
    .legal     (c_legal),
    .uses_bp   (c_uses_bp),
    .ovr_valid (ovr_valid),
    .ovr_seg   (ovr_seg),
    .seg_es    (seg_es),
    .seg_cs    (seg_cs),
    .seg_ss    (seg_ss),
    .seg_ds    (seg_ds),
    .seg_id    (c_seg_id),
    .seg_val   (c_seg_val)
  );

  eag_phys #(.OW(OW), .SEG_SHIFT(SEG_SHIFT)) u_phys (
    .legal   (c_legal),
    .seg_val (c_seg_val),
    .offset  (c_offset),
    .phys    (c_phys)
  );

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else if (accept) begin
      out_valid <= 1'b1;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_offset <= '0;
      out_seg    <= '0;
      out_phys   <= '0;
      out_err    <= 1'b0;
    end else if (accept) begin
      out_offset <= c_offset;
      out_seg    <= c_seg_id;
      out_phys   <= c_phys;
      out_err    <= !c_legal;
    end
  end
endmodule

// File: rtl/eag_top_chk.sv
module eag_top_chk #(
  parameter int OW        = 16,
  parameter int SEG_SHIFT = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic                    in_ready,
  input logic [2:0]              mode,
  input logic [1:0]              ptr_sel,
  input logic [OW-1:0]           disp,
  input logic                    ovr_valid,
  input logic [1:0]              ovr_seg,
  input logic                    out_valid,
  input logic                    out_ready,
  input logic [OW-1:0]           out_offset,
  input logic [1:0]              out_seg,
  input logic [OW+SEG_SHIFT-1:0] out_phys,
  input logic                    out_err
);
  logic acc;
  assign acc = in_valid && in_ready;

  assert_phys_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_err |-> out_phys[SEG_SHIFT-1:0] == out_offset[SEG_SHIFT-1:0]);

  assert_direct_R2: assert property (@(posedge clk) disable iff (!rst_n)
    acc && mode == 3'd0 && !ovr_valid |=> out_seg == 2'd3 && out_offset == $past(disp));

  assert_bp_stack_R3: assert property (@(posedge clk) disable iff (!rst_n)
    acc && mode == 3'd1 && ptr_sel == 2'd1 && !ovr_valid |=> out_seg == 2'd2);

  assert_override_R7: assert property (@(posedge clk) disable iff (!rst_n)
    acc && ovr_valid && mode <= 3'd4 |=> out_seg == $past(ovr_seg) && !out_err);

  assert_illegal_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    acc && mode > 3'd4 |=> out_err && out_phys == '0 && out_offset == '0 && out_seg == 2'd0);

  assert_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid);

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_phys) && $stable(out_offset)
      && $stable(out_seg) && $stable(out_err));
endmodule

bind eag_top eag_top_chk #(.OW(OW), .SEG_SHIFT(SEG_SHIFT)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .mode       (mode),
  .ptr_sel    (ptr_sel),
  .disp       (disp),
  .ovr_valid  (ovr_valid),
  .ovr_seg    (ovr_seg),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_offset (out_offset),
  .out_seg    (out_seg),
  .out_phys   (out_phys),
  .out_err    (out_err)
);

// File: tb/eag_top_test.sv
module eag_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [2:0]  mode = '0;
  logic [1:0]  ptr_sel = '0;
  logic        base_sel = 1'b0;
  logic        index_sel = 1'b0;
  logic [15:0] disp = '0;
  logic [15:0] reg_bx = '0, reg_bp = '0, reg_si = '0, reg_di = '0;
  logic [15:0] seg_es = '0, seg_cs = '0, seg_ss = '0, seg_ds = '0;
  logic        ovr_valid = 1'b0;
  logic [1:0]  ovr_seg = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [15:0] out_offset;
  logic [1:0]  out_seg;
  logic [19:0] out_phys;
  logic        out_err;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  typedef struct {
    int    off;
    int    seg;
    int    phys;
    int    err;
    string req;
  } exp_t;

  exp_t q[$];

  always #4 clk = ~clk;

  eag_top uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .mode(mode), .ptr_sel(ptr_sel), .base_sel(base_sel), .index_sel(index_sel),
    .disp(disp), .reg_bx(reg_bx), .reg_bp(reg_bp), .reg_si(reg_si), .reg_di(reg_di),
    .seg_es(seg_es), .seg_cs(seg_cs), .seg_ss(seg_ss), .seg_ds(seg_ds),
    .ovr_valid(ovr_valid), .ovr_seg(ovr_seg), .out_valid(out_valid),
    .out_ready(out_ready), .out_offset(out_offset), .out_seg(out_seg),
    .out_phys(out_phys), .out_err(out_err)
  );

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int pick_ptr(int code);
    case (code)
      0: return int'(reg_bx);
      1: return int'(reg_bp);
      2: return int'(reg_si);
      default: return int'(reg_di);
    endcase
  endfunction

  function automatic exp_t model();
    exp_t e;
    int base, idx, sv;
    bit bp_used;
    base = base_sel ? int'(reg_bp) : int'(reg_bx);
    idx  = index_sel ? int'(reg_di) : int'(reg_si);
    bp_used = 0;
    e.err = 0;
    case (int'(mode))
      0: begin e.off = int'(disp); e.req = "R2"; end
      1: begin e.off = pick_ptr(int'(ptr_sel)); bp_used = (ptr_sel == 2'd1); e.req = "R3"; end
      2: begin e.off = base + idx; bp_used = base_sel; e.req = "R4"; end
      3: begin e.off = pick_ptr(int'(ptr_sel)) + int'(disp); bp_used = (ptr_sel == 2'd1); e.req = "R5"; end
      4: begin e.off = base + idx + int'(disp); bp_used = base_sel; e.req = "R6"; end
      default: begin e.off = 0; e.err = 1; e.req = "R8"; end
    endcase
    e.off = e.off % 65536;
    if (e.err != 0) begin
      e.seg = 0; e.phys = 0;
    end else begin
      e.seg = bp_used ? 2 : 3;
      if (ovr_valid) begin e.seg = int'(ovr_seg); e.req = "R7"; end
      case (e.seg)
        0: sv = int'(seg_es);
        1: sv = int'(seg_cs);
        2: sv = int'(seg_ss);
        default: sv = int'(seg_ds);
      endcase
      e.phys = (sv * 16 + e.off) % 1048576;
    end
    return e;
  endfunction

  // Called just after a falling edge with the inputs for this cycle set.
  task automatic step();
    bit exp_rdy;
    #1;
    check("R9", "out_valid", int'(out_valid), (q.size() != 0) ? 1 : 0);
    if (q.size() != 0) begin
      check(q[0].req, "offset", int'(out_offset), q[0].off);
      check(q[0].req, "segment", int'(out_seg), q[0].seg);
      check("R1", "phys", int'(out_phys), q[0].phys);
      check("R8", "err", int'(out_err), q[0].err);
    end
    exp_rdy = (q.size() == 0) || out_ready;
    check("R9", "in_ready", int'(in_ready), int'(exp_rdy));
    if (q.size() != 0 && out_ready) void'(q.pop_front());
    if (in_valid && exp_rdy) q.push_back(model());
    @(negedge clk);
  endtask

  task automatic clear_fields();
    mode = 0; ptr_sel = 0; base_sel = 0; index_sel = 0; disp = 0;
    reg_bx = 0; reg_bp = 0; reg_si = 0; reg_di = 0;
    seg_es = 0; seg_cs = 0; seg_ss = 0; seg_ds = 0;
    ovr_valid = 0; ovr_seg = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      failures++;
      $display("FAIL R9 watchdog actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    // R10: reset holds out_valid low even with a request offered
    in_valid = 1'b1;
    out_ready = 1'b1;
    repeat (3) begin
      @(negedge clk);
      check("R10", "out_valid in reset", int'(out_valid), 0);
    end
    in_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    check("R10", "out_valid after reset", int'(out_valid), 0);
    step();

    // R4/R6: worked examples
    clear_fields();
    in_valid = 1; out_ready = 1;
    seg_ds = 16'h1100; reg_bx = 16'h2000; reg_si = 16'h0500; disp = 16'h0250;
    mode = 4; step();
    check("R6", "example phys", q.size() != 0 ? q[0].phys : -1, 'h13750);
    mode = 2; step();
    check("R4", "example phys", q.size() != 0 ? q[0].phys : -1, 'h13500);
    // R2: segment 010C offset 14D2
    clear_fields(); seg_ds = 16'h010C; disp = 16'h14D2; mode = 0; step();
    check("R2", "example phys", q.size() != 0 ? q[0].phys : -1, 'h02592);
    // R1: physical wrap past 2^20
    clear_fields(); seg_ds = 16'hFFFF; disp = 16'h0020; mode = 0; step();
    check("R1", "phys wrap", q.size() != 0 ? q[0].phys : -1, 'h00010);
    // R4: offset wrap, BP base picks the stack segment
    clear_fields(); seg_ss = 16'h3000; reg_bp = 16'hFFFF; reg_di = 16'h0002;
    base_sel = 1; index_sel = 1; mode = 2; step();
    // R5: negative displacement
    clear_fields(); seg_ds = 16'h0100; reg_si = 16'h0010; disp = 16'hFFFE;
    ptr_sel = 2; mode = 3; step();
    // R3: BP pointer selects the stack segment
    clear_fields(); seg_ss = 16'h0200; seg_ds = 16'h0900; reg_bp = 16'h0040;
    ptr_sel = 1; mode = 1; step();
    // R7: override on a BP base
    clear_fields(); seg_es = 16'h0A00; reg_bp = 16'h0010; reg_si = 16'h0001;
    base_sel = 1; ovr_valid = 1; ovr_seg = 0; mode = 2; step();
    // R8: illegal mode with an override present
    clear_fields(); seg_ds = 16'h1234; disp = 16'h5555; ovr_valid = 1; ovr_seg = 3;
    mode = 6; step();
    // R9: stall keeps the held result on the outputs
    clear_fields(); seg_ds = 16'h0040; disp = 16'h0008; mode = 0;
    out_ready = 0; step();
    in_valid = 0; repeat (3) step();
    out_ready = 1; step();
    step();

    // random traffic with random back-pressure
    for (int i = 0; i < 3000; i++) begin
      in_valid  = ($urandom_range(0, 3) != 0);
      out_ready = ($urandom_range(0, 3) != 0);
      mode      = 3'($urandom_range(0, 7));
      ptr_sel   = 2'($urandom_range(0, 3));
      base_sel  = 1'($urandom_range(0, 1));
      index_sel = 1'($urandom_range(0, 1));
      disp      = 16'($urandom);
      reg_bx = 16'($urandom); reg_bp = 16'($urandom);
      reg_si = 16'($urandom); reg_di = 16'($urandom);
      seg_es = 16'($urandom); seg_cs = 16'($urandom);
      seg_ss = 16'($urandom); seg_ds = 16'($urandom);
      ovr_valid = ($urandom_range(0, 3) == 0);
      ovr_seg   = 2'($urandom_range(0, 3));
      step();
    end
    in_valid = 0; out_ready = 1;
    repeat (3) step();
    finish_run();
  end
endmodule